// File: doc/BRIEF.md
# Two-Wire Sensor Register Slave with Word Access

This block is the host-facing register file of a light and proximity sensor. It sits on a two-wire I2C bus as a slave with a fixed 7-bit address. Each 8-bit command code selects a 16-bit register pair. Writes and reads always move the low byte first and then the high byte. The block finds start, stop and repeated-start conditions by oversampling the bus with the system clock. It shifts in the address, command and data bytes, and pulls the data line low through an open-drain enable to acknowledge a byte or to send a zero bit.

The first codes hold configuration and threshold words. The sensor logic reads these in parallel from a flat output vector. The codes above them are read-only. They return the live proximity result, the 16-bit ambient result and an interrupt flag byte. The sensor logic sets the flags with one-cycle pulses. Reading the flag byte out over the bus clears the flags that were captured for that read. A one-cycle strobe reports that the flag byte has been read.

Top module: `sregs_i2c_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address 0x60, which sits in bits 7:1 of the first byte after a start, with bit 0 as the direction (0 = write, 1 = read). Any other address gets no acknowledge, and no register changes.
- R2: A write transaction is: address with write, command code, low data byte, high data byte. Every byte is acknowledged. For codes 0x00 to 0x07 the two bytes land in bits 7:0 and 15:8 of word `code` on `cfg_o`, which is at `cfg_o[16*code +: 16]`.
- R3: A write that is stopped after only the low data byte changes only bits 7:0 of the addressed word. Data bytes after the high byte are acknowledged and ignored.
- R4: A read transaction is: address with write, command code, repeated start, address with read. The slave then sends the low byte and then the high byte, most significant bit first. The master acknowledges the low byte and does not acknowledge the high byte.
- R5: After reset every configuration word is 0x0000, the flag byte is 0x00, the data line is released and the strobe is low. Every configuration word reads back what was written.
- R6: Writes to codes 0x08 and above are acknowledged but change no stored value. Codes 0x0A and 0x0C to 0xFF read as 0x0000.
- R7: Code 0x08 reads the 8-bit proximity input in its low byte and 0x00 in its high byte. Code 0x09 reads the 16-bit ambient input, bits 7:0 first and then bits 15:8.
- R8: The flag byte is the high byte of code 0x0B, and the low byte of that code reads 0x00. Flag pulses are ORed into `flags_o` and stay set. When the flag byte has been fully shifted out, `flag_rd_o` pulses once and exactly the bits that were sent are cleared. A flag set during the read survives.
- R9: A start condition in any state restarts address reception. A stop returns the slave to idle with the data line released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_oe_o | output | 1 | 1 pulls the data line low (open drain) |
| prox_data_i | input | 8 | Live proximity result |
| amb_data_i | input | 16 | Live ambient light result |
| flag_set_i | input | 8 | One-cycle pulses that set interrupt flags |
| cfg_o | output | 128 | Configuration words 0..7, packed 16 bits each |
| flags_o | output | 8 | Current interrupt flag byte |
| flag_rd_o | output | 1 | One-cycle pulse after the flag byte has been sent |

## Verification
The bench targets the corner cases where byte order and byte count matter. A write stopped after the low byte must leave the high byte alone, so a design that committed both bytes at the stop would corrupt it. A read must deliver the low byte first, so a swapped design fails every readback. Writes to read-only codes and to a foreign address are checked at `cfg_o` and on readback, which exposes any design that decodes too loosely. A flag pulse placed in the middle of the flag byte's transfer must survive the clear; a design that cleared the whole register, or cleared it at load time, would lose that flag or raise the strobe too early.

// File: rtl/sregs_pkg.sv
package sregs_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    localparam logic [7:0] CODE_PROX = 8'h08;
    localparam logic [7:0] CODE_AMB  = 8'h09;
    localparam logic [7:0] CODE_FLAG = 8'h0B;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } bus_state_e;

    typedef enum logic [1:0] {
        RK_ADDR,
        RK_CMD,
        RK_DATA
    } rx_kind_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic              en;
        logic              hi;
        logic [BYTE_W-1:0] code;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic logic addr_match(input logic [7:0] b, input logic [6:0] a);
        return b[7:1] == a;
    endfunction

    function automatic logic is_rw_code(input logic [7:0] c, input int n);
        return int'(c) < n;
    endfunction

endpackage

// File: rtl/sregs_bus_cond.sv
module sregs_bus_cond
    import sregs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    logic [1:0] scl_s;
    logic [1:0] sda_s;
    logic       scl_q;
    logic       sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_s <= 2'b11;
            sda_s <= 2'b11;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_s <= {scl_s[0], scl_i};
            sda_s <= {sda_s[0], sda_i};
            scl_q <= scl_s[1];
            sda_q <= sda_s[1];
        end
    end

    always_comb begin
        ev_o.scl_rise = scl_s[1] & ~scl_q;
        ev_o.scl_fall = ~scl_s[1] & scl_q;
        ev_o.start    = scl_s[1] & scl_q & sda_q & ~sda_s[1];
        ev_o.stop     = scl_s[1] & scl_q & ~sda_q & sda_s[1];
        ev_o.sda      = sda_s[1];
    end
endmodule

// File: rtl/sregs_proto.sv
module sregs_proto
    import sregs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h60
) (
    input  logic        clk,
    input  logic        rst,
    input  bus_ev_t     ev_i,
    input  logic [15:0] rd_word_i,
    output logic        sda_oe_o,
    output wr_req_t     wr_o,
    output logic [7:0]  cmd_o,
    output logic        flag_rd_o,
    output logic [7:0]  clr_mask_o
);
    bus_state_e state;
    rx_kind_e   kind;
    logic [3:0] cnt;
    logic [7:0] sh;
    logic [7:0] tx_sh;
    logic [7:0] ld_byte;
    logic [1:0] wptr;
    logic       rd_hi;
    logic       go_tx;
    logic       mack_ok;

    assign cmd_o      = wr_o.code;
    assign clr_mask_o = ld_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            kind      <= RK_ADDR;
            cnt       <= '0;
            sh        <= '0;
            tx_sh     <= '0;
            ld_byte   <= '0;
            wptr      <= '0;
            rd_hi     <= 1'b0;
            go_tx     <= 1'b0;
            mack_ok   <= 1'b0;
            sda_oe_o  <= 1'b0;
            wr_o      <= '0;
            flag_rd_o <= 1'b0;
        end else begin
            wr_o.en   <= 1'b0;
            flag_rd_o <= 1'b0;
            if (ev_i.start) begin
                state    <= ST_RX;
                kind     <= RK_ADDR;
                cnt      <= '0;
                sda_oe_o <= 1'b0;
            end else if (ev_i.stop) begin
                state    <= ST_IDLE;
                sda_oe_o <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (ev_i.scl_rise && cnt != 4'd8) begin
                            sh  <= {sh[6:0], ev_i.sda};
                            cnt <= cnt + 4'd1;
                        end else if (ev_i.scl_fall && cnt == 4'd8) begin
                            cnt <= '0;
                            case (kind)
                                RK_ADDR: begin
                                    if (addr_match(sh, DEV_ADDR)) begin
                                        sda_oe_o <= 1'b1;
                                        state    <= ST_ACK;
                                        go_tx    <= sh[0];
                                        kind     <= RK_CMD;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                RK_CMD: begin
                                    wr_o.code <= sh;
                                    wptr      <= '0;
                                    sda_oe_o  <= 1'b1;
                                    state     <= ST_ACK;
                                    go_tx     <= 1'b0;
                                    kind      <= RK_DATA;
                                end
                                default: begin
                                    sda_oe_o <= 1'b1;
                                    state    <= ST_ACK;
                                    go_tx    <= 1'b0;
                                    if (wptr != 2'd2) begin
                                        wr_o.en   <= 1'b1;
                                        wr_o.hi   <= wptr[0];
                                        wr_o.data <= sh;
                                        wptr      <= wptr + 2'd1;
                                    end
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (ev_i.scl_fall) begin
                            if (go_tx) begin
                                tx_sh    <= rd_word_i[7:0];
                                ld_byte  <= rd_word_i[7:0];
                                sda_oe_o <= ~rd_word_i[7];
                                rd_hi    <= 1'b0;
                                cnt      <= 4'd1;
                                state    <= ST_TX;
                            end else begin
                                sda_oe_o <= 1'b0;
                                cnt      <= '0;
                                state    <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev_i.scl_fall) begin
                            if (cnt == 4'd8) begin
                                sda_oe_o <= 1'b0;
                                state    <= ST_MACK;
                                if (rd_hi && wr_o.code == CODE_FLAG) begin
                                    flag_rd_o <= 1'b1;
                                end
                            end else begin
                                sda_oe_o <= ~tx_sh[6];
                                tx_sh    <= {tx_sh[6:0], 1'b0};
                                cnt      <= cnt + 4'd1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (ev_i.scl_rise) begin
                            mack_ok <= ~ev_i.sda;
                        end else if (ev_i.scl_fall) begin
                            if (mack_ok) begin
                                tx_sh    <= rd_word_i[15:8];
                                ld_byte  <= rd_word_i[15:8];
                                sda_oe_o <= ~rd_word_i[15];
                                rd_hi    <= 1'b1;
                                cnt      <= 4'd1;
                                state    <= ST_TX;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R9: an idle slave never holds the data line
    a_r9_idle_released: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe_o);

    // R4: the driven level only changes while the clock line is low
    a_r4_hold_on_rise: assert property (@(posedge clk) disable iff (rst)
        ev_i.scl_rise |=> $stable(sda_oe_o));

    // R8: the clear strobe follows a completed byte transfer
    a_r8_strobe_after_tx: assert property (@(posedge clk) disable iff (rst)
        flag_rd_o |-> (state == ST_MACK && $past(state) == ST_TX));
endmodule

// File: rtl/sregs_bank.sv
module sregs_bank
    import sregs_pkg::*;
#(
    parameter int NUM_RW = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  wr_req_t                  wr_i,
    input  logic [7:0]               cmd_i,
    input  logic [7:0]               prox_i,
    input  logic [15:0]              amb_i,
    input  logic [7:0]               flag_set_i,
    input  logic                     flag_rd_i,
    input  logic [7:0]               clr_mask_i,
    output logic [15:0]              rd_word_o,
    output logic [NUM_RW*WORD_W-1:0] cfg_o,
    output logic [7:0]               flags_o
);
    localparam int IDX_W = (NUM_RW > 1) ? $clog2(NUM_RW) : 1;

    logic [NUM_RW*WORD_W-1:0] cfg_flat;
    logic [7:0]               flags_q;

    generate
        for (genvar g = 0; g < NUM_RW; g++) begin : g_word
            logic [WORD_W-1:0] word_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    word_q <= '0;
                end else if (wr_i.en && wr_i.code == 8'(g)) begin
                    if (wr_i.hi) word_q[15:8] <= wr_i.data;
                    else         word_q[7:0]  <= wr_i.data;
                end
            end
            assign cfg_flat[g*WORD_W +: WORD_W] = word_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~(flag_rd_i ? clr_mask_i : 8'h00)) | flag_set_i;
    end

    always_comb begin
        rd_word_o = '0;
        if (is_rw_code(cmd_i, NUM_RW)) begin
            rd_word_o = cfg_flat[WORD_W*int'(cmd_i[IDX_W-1:0]) +: WORD_W];
        end else begin
            case (cmd_i)
                CODE_PROX: rd_word_o = {8'h00, prox_i};
                CODE_AMB:  rd_word_o = amb_i;
                CODE_FLAG: rd_word_o = {flags_q, 8'h00};
                default:   rd_word_o = '0;
            endcase
        end
    end

    assign cfg_o   = cfg_flat;
    assign flags_o = flags_q;

    // R6: read-only codes leave the stored words untouched
    a_r6_ro_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_i.en && !is_rw_code(wr_i.code, NUM_RW)) |=> $stable(cfg_flat));

    // R2: a low-byte write lands in bits 7:0 of the addressed word
    a_r2_low_lands: assert property (@(posedge clk) disable iff (rst)
        (wr_i.en && is_rw_code(wr_i.code, NUM_RW) && !wr_i.hi) |=>
        (cfg_flat[WORD_W*int'($past(wr_i.code[IDX_W-1:0])) +: 8] == $past(wr_i.data)));

    // R8: the sent bits are cleared unless set again in the same cycle
    a_r8_clear_sent: assert property (@(posedge clk) disable iff (rst)
        flag_rd_i |=> ((flags_q & $past(clr_mask_i) & ~$past(flag_set_i)) == 8'h00));

    // R8: without a read no flag ever drops
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        !flag_rd_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/sregs_i2c_slave.sv
module sregs_i2c_slave
    import sregs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h60,
    parameter int         NUM_RW   = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     scl_i,
    input  logic                     sda_i,
    output logic                     sda_oe_o,
    input  logic [7:0]               prox_data_i,
    input  logic [15:0]              amb_data_i,
    input  logic [7:0]               flag_set_i,
    output logic [NUM_RW*WORD_W-1:0] cfg_o,
    output logic [7:0]               flags_o,
    output logic                     flag_rd_o
);
    bus_ev_t     ev;
    wr_req_t     wr;
    logic [7:0]  cmd;
    logic [15:0] rd_word;
    logic [7:0]  clr_mask;

    sregs_bus_cond u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    sregs_proto #(.DEV_ADDR(DEV_ADDR)) u_proto (
        .clk        (clk),
        .rst        (rst),
        .ev_i       (ev),
        .rd_word_i  (rd_word),
        .sda_oe_o   (sda_oe_o),
        .wr_o       (wr),
        .cmd_o      (cmd),
        .flag_rd_o  (flag_rd_o),
        .clr_mask_o (clr_mask)
    );

    sregs_bank #(.NUM_RW(NUM_RW)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr_i       (wr),
        .cmd_i      (cmd),
        .prox_i     (prox_data_i),
        .amb_i      (amb_data_i),
        .flag_set_i (flag_set_i),
        .flag_rd_i  (flag_rd_o),
        .clr_mask_i (clr_mask),
        .rd_word_o  (rd_word),
        .cfg_o      (cfg_o),
        .flags_o    (flags_o)
    );
endmodule

// File: tb/sregs_i2c_slave_tb.sv
module sregs_i2c_slave_tb;
    localparam int Q = 5;
    localparam logic [6:0] ADDR = 7'h60;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         scl = 1'b1;
    logic         sda_m = 1'b1;
    logic         sda_oe;
    logic [7:0]   prox = 8'h00;
    logic [15:0]  amb = 16'h0000;
    logic [7:0]   fset = 8'h00;
    logic [127:0] cfg;
    logic [7:0]   flags;
    logic         frd;
    logic         sda_line;

    int tests = 0;
    int fails = 0;
    int rd_pulses = 0;
    logic [127:0] exp_cfg = '0;
    logic [7:0]   exp_flags = 8'h00;

    assign sda_line = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    sregs_i2c_slave u_dut (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .prox_data_i (prox),
        .amb_data_i  (amb),
        .flag_set_i  (fset),
        .cfg_o       (cfg),
        .flags_o     (flags),
        .flag_rd_o   (frd)
    );

    always @(posedge clk) if (!rst && frd) rd_pulses++;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl = 1'b0; wt(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b1; wt(2*Q);
    endtask

    task automatic wbit(input logic b);
        sda_m = b; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q);
    endtask

    task automatic rbit(output logic b);
        sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); b = sda_line; wt(Q); scl = 1'b0; wt(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(x);
        ack = ~x;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic mack);
        logic x;
        for (int i = 7; i >= 0; i--) begin rbit(x); v[i] = x; end
        wbit(~mack);
    endtask

    task automatic pulse_flags(input logic [7:0] v);
        fset = v; @(negedge clk); fset = 8'h00;
        exp_flags = exp_flags | v;
    endtask

    task automatic wr_word(input logic [6:0] a, input logic [7:0] code, input logic [7:0] lo,
                           input logic [7:0] hi, input logic only_lo, output logic ok);
        logic a0, a1, a2, a3;
        bus_start();
        send_byte({a, 1'b0}, a0);
        send_byte(code, a1);
        send_byte(lo, a2);
        a3 = 1'b1;
        if (!only_lo) send_byte(hi, a3);
        bus_stop();
        ok = a0 & a1 & a2 & a3;
        if (ok && a == ADDR && code < 8'd8) begin
            exp_cfg[16*code +: 8] = lo;
            if (!only_lo) exp_cfg[16*code + 8 +: 8] = hi;
        end
    endtask

    task automatic rd_word(input logic [7:0] code, output logic [15:0] w, output logic ok);
        logic a0, a1, a2;
        bus_start();
        send_byte({ADDR, 1'b0}, a0);
        send_byte(code, a1);
        bus_start();
        send_byte({ADDR, 1'b1}, a2);
        recv_byte(w[7:0], 1'b1);
        recv_byte(w[15:8], 1'b0);
        bus_stop();
        ok = a0 & a1 & a2;
    endtask

    function automatic logic [15:0] exp_rd(input logic [7:0] c);
        if (c < 8'd8)        return exp_cfg[16*c +: 16];
        else if (c == 8'h08) return {8'h00, prox};
        else if (c == 8'h09) return amb;
        else if (c == 8'h0B) return {exp_flags, 8'h00};
        return 16'h0000;
    endfunction

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic ok;
        logic [15:0] w;
        int p0;
        void'($urandom(32'd1234));
        wt(4); rst = 1'b0; wt(4);

        // R5 reset state
        chk("R5 cfg reset", cfg, 128'h0);
        chk("R5 flags reset", flags, 8'h00);
        chk("R5 sda released", sda_oe, 1'b0);
        chk("R5 strobe low", frd, 1'b0);

        // R2 full write and R4 ordered readback
        wr_word(ADDR, 8'h03, 8'hA5, 8'h5A, 1'b0, ok);
        chk("R2 write acked", ok, 1'b1);
        chk("R2 cfg word 3", cfg[48 +: 16], 16'h5AA5);
        rd_word(8'h03, w, ok);
        chk("R4 read acked", ok, 1'b1);
        chk("R4 low then high", w, 16'h5AA5);

        // R3 partial write
        wr_word(ADDR, 8'h05, 8'h33, 8'h22, 1'b0, ok);
        wr_word(ADDR, 8'h05, 8'h11, 8'h00, 1'b1, ok);
        chk("R3 low only", cfg[80 +: 16], 16'h2211);

        // R1 foreign address
        wr_word(7'h61, 8'h03, 8'hFF, 8'hFF, 1'b0, ok);
        chk("R1 no ack other addr", ok, 1'b0);
        chk("R1 cfg unchanged", cfg, exp_cfg);
        wr_word(7'h20, 8'h05, 8'hFF, 8'hFF, 1'b0, ok);
        chk("R1 no ack top bit", ok, 1'b0);

        // R9 released after stop, clean restart
        chk("R9 idle released", sda_oe, 1'b0);

        // R7 live data
        prox = 8'hC3; amb = 16'hBEEF;
        rd_word(8'h08, w, ok);
        chk("R7 prox word", w, 16'h00C3);
        rd_word(8'h09, w, ok);
        chk("R7 amb word", w, 16'hBEEF);

        // R6 read-only codes
        wr_word(ADDR, 8'h09, 8'h12, 8'h34, 1'b0, ok);
        chk("R6 ro write acked", ok, 1'b1);
        chk("R6 cfg untouched", cfg, exp_cfg);
        rd_word(8'h09, w, ok);
        chk("R6 amb still live", w, 16'hBEEF);
        rd_word(8'h0C, w, ok);
        chk("R6 reserved reads zero", w, 16'h0000);

        // R8 flag set, read, clear
        pulse_flags(8'h91);
        wt(2);
        chk("R8 flags set", flags, 8'h91);
        p0 = rd_pulses;
        rd_word(8'h0B, w, ok);
        chk("R8 flag word", w, 16'h9100);
        chk("R8 cleared", flags, 8'h00);
        chk("R8 one strobe", rd_pulses - p0, 1);
        exp_flags = 8'h00;
        p0 = rd_pulses;
        rd_word(8'h09, w, ok);
        chk("R8 no strobe other code", rd_pulses - p0, 0);

        // R8 flag raised during the flag byte transfer survives
        begin
            logic a0, a1, a2, x;
            logic [7:0] lo, hi;
            pulse_flags(8'h80);
            bus_start();
            send_byte({ADDR, 1'b0}, a0);
            send_byte(8'h0B, a1);
            bus_start();
            send_byte({ADDR, 1'b1}, a2);
            recv_byte(lo, 1'b1);
            for (int i = 7; i >= 0; i--) begin
                rbit(x); hi[i] = x;
                if (i == 5) fset = 8'h01;
                if (i == 5) @(negedge clk);
                fset = 8'h00;
            end
            wbit(1'b1);
            bus_stop();
            chk("R8 sent old flags", hi, 8'h80);
            chk("R8 late flag kept", flags, 8'h01);
            exp_flags = 8'h01;
        end

        // random mix against the model
        for (int it = 0; it < 40; it++) begin
            int op;
            op = int'($urandom % 4);
            if (op < 2) begin
                logic [7:0] c;
                c = 8'($urandom % 16);
                wr_word(ADDR, c, 8'($urandom), 8'($urandom), ($urandom % 4) == 0, ok);
                chk("R2 rand write ack", ok, 1'b1);
                chk("R6 rand cfg", cfg, exp_cfg);
            end else if (op == 2) begin
                logic [7:0] c;
                logic [15:0] e;
                c = 8'($urandom % 16);
                prox = 8'($urandom); amb = 16'($urandom);
                e = exp_rd(c);
                rd_word(c, w, ok);
                chk("R4 rand read", w, e);
                if (c == 8'h0B) exp_flags = 8'h00;
            end else begin
                pulse_flags(8'($urandom));
                wt(2);
                chk("R8 rand flags", flags, exp_flags);
            end
        end

        summary();
        $finish;
    end
endmodule